// File: doc/BRIEF.md
# Macro-op expanding decode packer

This block is the decode stage of an in-order pipeline. Fetch delivers lines of instruction slots into a small line buffer. Each cycle, the stage walks the buffered slots from its saved position and fills a fixed-width output line. Plain instructions are copied through. Faulted slots are forwarded with their fields intact. Empty (bubble) slots are dropped. A macro-op is broken into a run of micro-ops, each tagged with its own micro-PC. Every emitted slot is stamped with a running execution sequence number.

A macro-op whose expansion does not fit in the current output line resumes in the next cycle, at the micro-PC where it stopped. A configuration input lets the walk continue into the next buffered line in the same cycle once the head line is used up. The walk covers at most two lines per cycle. The stage does nothing in a cycle when the downstream stage cannot reserve space. Results appear on registered outputs one clock after the cycle in which they were packed. `out_valid` acts as the reservation pulse toward the next stage.

Micro-op content is not decoded for real. A macro-op carries a micro-op count. Each micro-op payload is the macro-op payload XOR an entry from a small computed table.

Top module: `uop_pack_stage`

## Requirements
- R1: After synchronous reset, `out_valid`, every bit of `out_slot_vld` and `in_full` are 0, and the first slot emitted afterwards carries sequence number 0.
- R2: A valid, non-fault, non-macro slot is emitted with kind 0 (plain), micro-PC 0, and pc, prediction flag, prediction target and payload copied. Emitted slots fill output positions from 0 upward in buffer order, at most OUT_W per cycle. Positions not filled have `out_slot_vld` low.
- R3: A slot with `in_vld` low emits nothing. It is consumed and clears any in-progress macro-op state.
- R4: A slot with `in_vld` and `in_fault` high is emitted with kind 2 (fault), micro-PC 0, and all its fields unchanged, whatever its macro flag says.
- R5: A valid, non-fault slot with `in_macro` high emits max(count,1) micro-ops of kind 1, where count is its `in_ucnt` field. They carry micro-PC 0,1,2,... in order, the macro-op's pc, and payload = macro payload XOR T[micro-PC], with T[k] = (37*k + 5) mod 2^OP_W.
- R6: Only the last micro-op of a macro-op carries the macro-op's prediction flag and target. Earlier micro-ops carry flag 0 and target 0.
- R7: A macro-op expansion that fills the output line resumes in the next active cycle at the following micro-PC. The slot is consumed only when its last micro-op is emitted.
- R8: Each emitted slot takes the current sequence number, which then increments by one, wrapping modulo 2^SEQ_W. Sequence numbers are contiguous across positions and cycles.
- R9: A fully consumed line leaves the buffer. When `cfg_multi_line` is 1 and a second line was buffered at the start of the cycle, packing continues into it in the same cycle. When it is 0, packing stops at the end of the line.
- R10: While `ds_can_reserve` is 0, nothing is consumed and `out_valid` is 0 on the next clock. `out_valid` is 1 only after a cycle in which at least one slot was emitted.
- R11: A line offered with `in_push` is visible to packing from the next cycle on. `in_full` is 1 exactly when BUF_DEPTH lines are held, and a push while `in_full` is 1 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_multi_line | input | 1 | Allow packing to continue into the next buffered line |
| in_push | input | 1 | Offer an input line this cycle |
| in_vld | input | IN_W | Per-slot occupied flag (0 = bubble) |
| in_fault | input | IN_W | Per-slot fault flag |
| in_macro | input | IN_W | Per-slot macro-op flag |
| in_ucnt | input | IN_W*UC_W | Per-slot micro-op count |
| in_pc | input | IN_W*PC_W | Per-slot instruction address |
| in_ptaken | input | IN_W | Per-slot predicted-taken flag |
| in_ptgt | input | IN_W*PC_W | Per-slot predicted target |
| in_op | input | IN_W*OP_W | Per-slot payload |
| in_full | output | 1 | Line buffer holds BUF_DEPTH lines |
| ds_can_reserve | input | 1 | Next stage can accept an output line |
| out_valid | output | 1 | Output line holds at least one slot (reservation pulse) |
| out_slot_vld | output | OUT_W | Per-position valid |
| out_kind | output | OUT_W*2 | Per-position kind: 0 plain, 1 micro-op, 2 fault |
| out_pc | output | OUT_W*PC_W | Per-position pc |
| out_upc | output | OUT_W*UC_W | Per-position micro-PC |
| out_ptaken | output | OUT_W | Per-position predicted-taken |
| out_ptgt | output | OUT_W*PC_W | Per-position predicted target |
| out_op | output | OUT_W*OP_W | Per-position payload |
| out_seq | output | OUT_W*SEQ_W | Per-position execution sequence number |

## Verification
The bench aims at macro-ops that straddle the output boundary. A design that loses the saved micro-PC would restart the expansion at micro-PC 0 or skip micro-ops. It also aims at prediction placement, where a wrong design would tag every micro-op or none with the prediction. It runs lines made only of bubbles and line ends with and without the multi-line setting. A wrong design would then either emit an empty `out_valid` pulse or fail to pop the line. It also pulls the wrong line into the cycle. Stalled cycles and a full buffer expose designs that keep consuming under back-pressure or accept a fifth line. A long random run wraps the sequence counter, which catches gaps or repeats in numbering.

// File: rtl/uop_pack_pkg.sv
package uop_pack_pkg;
  typedef enum logic [1:0] {
    SK_PLAIN = 2'd0,
    SK_UOP   = 2'd1,
    SK_FAULT = 2'd2
  } slot_kind_e;
endpackage

// File: rtl/uop_line_fifo.sv
module uop_line_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic [1:0]   pop,
  output logic         full,
  output logic         has1,
  output logic         has2,
  output logic [W-1:0] dout0,
  output logic [W-1:0] dout1
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1) + 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_p, rd_p, rd_p1, rd_p2;
  logic [CNT_W-1:0] cnt;
  logic             push_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rd_p1   = ptr_inc(rd_p);
  assign rd_p2   = ptr_inc(rd_p1);
  assign full    = (cnt == CNT_W'(DEPTH));
  assign has1    = (cnt >= CNT_W'(1));
  assign has2    = (cnt >= CNT_W'(2));
  assign push_ok = push && !full;
  assign dout0   = mem[rd_p];
  assign dout1   = mem[rd_p1];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_p] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_p <= '0;
      rd_p <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wr_p <= ptr_inc(wr_p);
      case (pop)
        2'd1:    rd_p <= rd_p1;
        2'd2:    rd_p <= rd_p2;
        default: rd_p <= rd_p;
      endcase
      cnt <= cnt + CNT_W'(push_ok) - CNT_W'(pop);
    end
  end

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));
  p_pop_held_r9: assert property (@(posedge clk) disable iff (rst)
    CNT_W'(pop) <= cnt);
endmodule

// File: rtl/uop_rom.sv
module uop_rom #(
  parameter int UC_W = 3,
  parameter int OP_W = 8
) (
  output logic [(1<<UC_W)-1:0][OP_W-1:0] tbl
);
  localparam int N = 1 << UC_W;
  for (genvar k = 0; k < N; k++) begin : g_ent
    assign tbl[k] = OP_W'(k * 37 + 5);
  end
endmodule

// File: rtl/uop_pack_walk.sv
module uop_pack_walk
  import uop_pack_pkg::*;
#(
  parameter int IN_W  = 4,
  parameter int OUT_W = 4,
  parameter int PC_W  = 16,
  parameter int OP_W  = 8,
  parameter int UC_W  = 3,
  parameter int SEQ_W = 8,
  parameter int IX_W  = 2
) (
  input  logic [1:0]                            have,
  input  logic [1:0][IN_W-1:0]                  vld,
  input  logic [1:0][IN_W-1:0]                  flt,
  input  logic [1:0][IN_W-1:0]                  mac,
  input  logic [1:0][IN_W-1:0][UC_W-1:0]        ucnt,
  input  logic [1:0][IN_W-1:0][PC_W-1:0]        pc,
  input  logic [1:0][IN_W-1:0]                  ptk,
  input  logic [1:0][IN_W-1:0][PC_W-1:0]        ptg,
  input  logic [1:0][IN_W-1:0][OP_W-1:0]        op,
  input  logic [(1<<UC_W)-1:0][OP_W-1:0]        rom,
  input  logic [IX_W-1:0]                       st_idx,
  input  logic                                  st_inmac,
  input  logic [UC_W-1:0]                       st_upc,
  input  logic [SEQ_W-1:0]                      st_seq,
  output logic [IX_W-1:0]                       nx_idx,
  output logic                                  nx_inmac,
  output logic [UC_W-1:0]                       nx_upc,
  output logic [SEQ_W-1:0]                      nx_seq,
  output logic [1:0]                            pops,
  output logic [OUT_W-1:0]                      o_vld,
  output logic [OUT_W-1:0][1:0]                 o_kind,
  output logic [OUT_W-1:0][PC_W-1:0]            o_pc,
  output logic [OUT_W-1:0][UC_W-1:0]            o_upc,
  output logic [OUT_W-1:0]                      o_ptk,
  output logic [OUT_W-1:0][PC_W-1:0]            o_ptg,
  output logic [OUT_W-1:0][OP_W-1:0]            o_op,
  output logic [OUT_W-1:0][SEQ_W-1:0]           o_seq
);
  // Each step either consumes a slot or emits one, so this bound covers
  // two whole lines plus a full output line.
  localparam int STEPS = OUT_W + 2 * IN_W;

  always_comb begin
    int ln, ix, oi, npop;
    logic im, adv, emit, last;
    logic [UC_W-1:0]  up;
    logic [SEQ_W-1:0] sq;
    logic c_v, c_f, c_m, c_pt;
    logic [UC_W-1:0] c_n;
    logic [PC_W-1:0] c_pc, c_pg;
    logic [OP_W-1:0] c_op;
    slot_kind_e e_k;
    logic [UC_W-1:0] e_up;
    logic e_pt;
    logic [PC_W-1:0] e_pg;
    logic [OP_W-1:0] e_op;

    o_vld  = '0;
    o_kind = '0;
    o_pc   = '0;
    o_upc  = '0;
    o_ptk  = '0;
    o_ptg  = '0;
    o_op   = '0;
    o_seq  = '0;
    ln   = 0;
    ix   = int'(st_idx);
    oi   = 0;
    npop = 0;
    im   = st_inmac;
    up   = st_upc;
    sq   = st_seq;

    for (int s = 0; s < STEPS; s++) begin
      c_v = 1'b0; c_f = 1'b0; c_m = 1'b0; c_pt = 1'b0;
      c_n = '0; c_pc = '0; c_pg = '0; c_op = '0;
      e_k = SK_PLAIN; e_up = '0; e_pt = 1'b0; e_pg = '0; e_op = '0;
      adv = 1'b0; emit = 1'b0; last = 1'b0;
      if (ln < 2 && have[ln[0]] && oi < OUT_W) begin
        for (int l = 0; l < 2; l++) begin
          for (int j = 0; j < IN_W; j++) begin
            if (l == ln && j == ix) begin
              c_v  = vld[l][j];  c_f  = flt[l][j];  c_m = mac[l][j];
              c_n  = ucnt[l][j]; c_pc = pc[l][j];   c_pt = ptk[l][j];
              c_pg = ptg[l][j];  c_op = op[l][j];
            end
          end
        end
        if (!c_v) begin
          adv = 1'b1;
        end else if (c_f) begin
          emit = 1'b1; e_k = SK_FAULT;
          e_pt = c_pt; e_pg = c_pg; e_op = c_op;
          adv  = 1'b1;
        end else if (c_m) begin
          if (!im) begin
            up = '0;
            im = 1'b1;
          end
          last = ({1'b0, up} + 1'b1) >= {1'b0, c_n};
          emit = 1'b1; e_k = SK_UOP; e_up = up;
          e_op = c_op ^ rom[up];
          e_pt = last ? c_pt : 1'b0;
          e_pg = last ? c_pg : '0;
          if (last) adv = 1'b1;
          else      up  = up + 1'b1;
        end else begin
          emit = 1'b1; e_k = SK_PLAIN;
          e_pt = c_pt; e_pg = c_pg; e_op = c_op;
          adv  = 1'b1;
        end

        if (emit) begin
          for (int k = 0; k < OUT_W; k++) begin
            if (k == oi) begin
              o_vld[k]  = 1'b1;
              o_kind[k] = e_k;
              o_pc[k]   = c_pc;
              o_upc[k]  = e_up;
              o_ptk[k]  = e_pt;
              o_ptg[k]  = e_pg;
              o_op[k]   = e_op;
              o_seq[k]  = sq;
            end
          end
          sq = sq + 1'b1;
          oi = oi + 1;
        end
        if (adv) begin
          ix = ix + 1;
          im = 1'b0;
          up = '0;
        end
        if (ix == IN_W) begin
          ix   = 0;
          ln   = ln + 1;
          npop = npop + 1;
          im   = 1'b0;
          up   = '0;
        end
      end
    end

    nx_idx   = IX_W'(ix);
    nx_inmac = im;
    nx_upc   = up;
    nx_seq   = sq;
    pops     = 2'(npop);
  end
endmodule

// File: rtl/uop_pack_stage.sv
module uop_pack_stage
  import uop_pack_pkg::*;
#(
  parameter int IN_W      = 4,
  parameter int OUT_W     = 4,
  parameter int BUF_DEPTH = 4,
  parameter int PC_W      = 16,
  parameter int OP_W      = 8,
  parameter int UC_W      = 3,
  parameter int SEQ_W     = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_multi_line,
  input  logic                    in_push,
  input  logic [IN_W-1:0]         in_vld,
  input  logic [IN_W-1:0]         in_fault,
  input  logic [IN_W-1:0]         in_macro,
  input  logic [IN_W*UC_W-1:0]    in_ucnt,
  input  logic [IN_W*PC_W-1:0]    in_pc,
  input  logic [IN_W-1:0]         in_ptaken,
  input  logic [IN_W*PC_W-1:0]    in_ptgt,
  input  logic [IN_W*OP_W-1:0]    in_op,
  output logic                    in_full,
  input  logic                    ds_can_reserve,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_slot_vld,
  output logic [OUT_W*2-1:0]      out_kind,
  output logic [OUT_W*PC_W-1:0]   out_pc,
  output logic [OUT_W*UC_W-1:0]   out_upc,
  output logic [OUT_W-1:0]        out_ptaken,
  output logic [OUT_W*PC_W-1:0]   out_ptgt,
  output logic [OUT_W*OP_W-1:0]   out_op,
  output logic [OUT_W*SEQ_W-1:0]  out_seq
);
  localparam int IX_W   = (IN_W > 1) ? $clog2(IN_W) : 1;
  localparam int O_FLT  = IN_W;
  localparam int O_MAC  = 2 * IN_W;
  localparam int O_CNT  = 3 * IN_W;
  localparam int O_PC   = O_CNT + IN_W * UC_W;
  localparam int O_PTK  = O_PC + IN_W * PC_W;
  localparam int O_PTG  = O_PTK + IN_W;
  localparam int O_OP   = O_PTG + IN_W * PC_W;
  localparam int LINE_W = O_OP + IN_W * OP_W;

  logic [LINE_W-1:0] line_in, line0, line1;
  logic [LINE_W-1:0] lines [2];
  logic              has1, has2;
  logic [1:0]        pops, fifo_pop;

  assign line_in = {in_op, in_ptgt, in_ptaken, in_pc, in_ucnt, in_macro, in_fault, in_vld};

  uop_line_fifo #(.W(LINE_W), .DEPTH(BUF_DEPTH)) u_fifo (
    .clk  (clk),
    .rst  (rst),
    .push (in_push),
    .din  (line_in),
    .pop  (fifo_pop),
    .full (in_full),
    .has1 (has1),
    .has2 (has2),
    .dout0(line0),
    .dout1(line1)
  );

  assign lines[0] = line0;
  assign lines[1] = line1;

  logic [1:0][IN_W-1:0]           w_vld, w_flt, w_mac, w_ptk;
  logic [1:0][IN_W-1:0][UC_W-1:0] w_cnt;
  logic [1:0][IN_W-1:0][PC_W-1:0] w_pc, w_ptg;
  logic [1:0][IN_W-1:0][OP_W-1:0] w_op;

  for (genvar l = 0; l < 2; l++) begin : g_unpack
    assign w_vld[l] = lines[l][O_FLT-1:0];
    assign w_flt[l] = lines[l][O_MAC-1:O_FLT];
    assign w_mac[l] = lines[l][O_CNT-1:O_MAC];
    assign w_cnt[l] = lines[l][O_PC-1:O_CNT];
    assign w_pc[l]  = lines[l][O_PTK-1:O_PC];
    assign w_ptk[l] = lines[l][O_PTG-1:O_PTK];
    assign w_ptg[l] = lines[l][O_OP-1:O_PTG];
    assign w_op[l]  = lines[l][LINE_W-1:O_OP];
  end

  logic [(1<<UC_W)-1:0][OP_W-1:0] rom;
  uop_rom #(.UC_W(UC_W), .OP_W(OP_W)) u_rom (.tbl(rom));

  logic [IX_W-1:0]  st_idx, nx_idx;
  logic             st_inmac, nx_inmac;
  logic [UC_W-1:0]  st_upc, nx_upc;
  logic [SEQ_W-1:0] st_seq, nx_seq;
  logic [1:0]       have;

  logic [OUT_W-1:0]             n_vld, n_ptk;
  logic [OUT_W-1:0][1:0]        n_kind;
  logic [OUT_W-1:0][PC_W-1:0]   n_pc, n_ptg;
  logic [OUT_W-1:0][UC_W-1:0]   n_upc;
  logic [OUT_W-1:0][OP_W-1:0]   n_op;
  logic [OUT_W-1:0][SEQ_W-1:0]  n_seq;

  assign have     = {has2 && cfg_multi_line, has1};
  assign fifo_pop = ds_can_reserve ? pops : 2'd0;

  uop_pack_walk #(
    .IN_W(IN_W), .OUT_W(OUT_W), .PC_W(PC_W), .OP_W(OP_W),
    .UC_W(UC_W), .SEQ_W(SEQ_W), .IX_W(IX_W)
  ) u_walk (
    .have(have), .vld(w_vld), .flt(w_flt), .mac(w_mac), .ucnt(w_cnt),
    .pc(w_pc), .ptk(w_ptk), .ptg(w_ptg), .op(w_op), .rom(rom),
    .st_idx(st_idx), .st_inmac(st_inmac), .st_upc(st_upc), .st_seq(st_seq),
    .nx_idx(nx_idx), .nx_inmac(nx_inmac), .nx_upc(nx_upc), .nx_seq(nx_seq),
    .pops(pops),
    .o_vld(n_vld), .o_kind(n_kind), .o_pc(n_pc), .o_upc(n_upc),
    .o_ptk(n_ptk), .o_ptg(n_ptg), .o_op(n_op), .o_seq(n_seq)
  );

  logic [OUT_W-1:0]             q_vld, q_ptk;
  logic [OUT_W-1:0][1:0]        q_kind;
  logic [OUT_W-1:0][PC_W-1:0]   q_pc, q_ptg;
  logic [OUT_W-1:0][UC_W-1:0]   q_upc;
  logic [OUT_W-1:0][OP_W-1:0]   q_op;
  logic [OUT_W-1:0][SEQ_W-1:0]  q_seq;
  logic                         q_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_idx   <= '0;
      st_inmac <= 1'b0;
      st_upc   <= '0;
      st_seq   <= '0;
      q_out    <= 1'b0;
      q_vld    <= '0;
      q_kind   <= '0;
      q_pc     <= '0;
      q_upc    <= '0;
      q_ptk    <= '0;
      q_ptg    <= '0;
      q_op     <= '0;
      q_seq    <= '0;
    end else if (ds_can_reserve) begin
      st_idx   <= nx_idx;
      st_inmac <= nx_inmac;
      st_upc   <= nx_upc;
      st_seq   <= nx_seq;
      q_out    <= |n_vld;
      q_vld    <= n_vld;
      q_kind   <= n_kind;
      q_pc     <= n_pc;
      q_upc    <= n_upc;
      q_ptk    <= n_ptk;
      q_ptg    <= n_ptg;
      q_op     <= n_op;
      q_seq    <= n_seq;
    end else begin
      q_out <= 1'b0;
      q_vld <= '0;
    end
  end

  assign out_valid    = q_out;
  assign out_slot_vld = q_vld;
  assign out_kind     = q_kind;
  assign out_pc       = q_pc;
  assign out_upc      = q_upc;
  assign out_ptaken   = q_ptk;
  assign out_ptgt     = q_ptg;
  assign out_op       = q_op;
  assign out_seq      = q_seq;

  p_blocked_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !ds_can_reserve |=> !out_valid);
  p_pack_low_r2: assert property (@(posedge clk) disable iff (rst)
    (q_vld & (q_vld + 1'b1)) == '0);
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !ds_can_reserve |=> $stable(st_seq) && $stable(st_idx));
  for (genvar k = 1; k < OUT_W; k++) begin : g_seq_chk
    p_seq_consec_r8: assert property (@(posedge clk) disable iff (rst)
      q_vld[k] |-> q_seq[k] == q_seq[k-1] + 1'b1);
  end
  for (genvar k = 0; k < OUT_W; k++) begin : g_upc_chk
    p_nonuop_upc_r5: assert property (@(posedge clk) disable iff (rst)
      (q_vld[k] && q_kind[k] != SK_UOP) |-> q_upc[k] == '0);
  end
endmodule

// File: tb/uop_pack_stage_tb_top.sv
`timescale 1ns/1ps
module uop_pack_stage_tb_top;
  localparam int IN_W = 4, OUT_W = 4, DEPTH = 4;
  localparam int PC_W = 16, OP_W = 8, UC_W = 3, SEQ_W = 8;

  typedef struct packed {
    logic v, f, m;
    logic [UC_W-1:0] n;
    logic [PC_W-1:0] pc;
    logic pt;
    logic [PC_W-1:0] pg;
    logic [OP_W-1:0] op;
  } mslot_t;
  typedef mslot_t [IN_W-1:0] mline_t;
  typedef struct packed {
    logic [1:0] k;
    logic [PC_W-1:0] pc;
    logic [UC_W-1:0] up;
    logic pt;
    logic [PC_W-1:0] pg;
    logic [OP_W-1:0] op;
  } mout_t;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_multi_line = 1'b0, in_push = 1'b0, ds_can_reserve = 1'b0;
  logic [IN_W-1:0] in_vld = '0, in_fault = '0, in_macro = '0, in_ptaken = '0;
  logic [IN_W*UC_W-1:0] in_ucnt = '0;
  logic [IN_W*PC_W-1:0] in_pc = '0, in_ptgt = '0;
  logic [IN_W*OP_W-1:0] in_op = '0;
  logic in_full, out_valid;
  logic [OUT_W-1:0] out_slot_vld, out_ptaken;
  logic [OUT_W*2-1:0] out_kind;
  logic [OUT_W*PC_W-1:0] out_pc, out_ptgt;
  logic [OUT_W*UC_W-1:0] out_upc;
  logic [OUT_W*OP_W-1:0] out_op;
  logic [OUT_W*SEQ_W-1:0] out_seq;

  always #4 clk = ~clk;

  uop_pack_stage #(.IN_W(IN_W), .OUT_W(OUT_W), .BUF_DEPTH(DEPTH), .PC_W(PC_W),
    .OP_W(OP_W), .UC_W(UC_W), .SEQ_W(SEQ_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_multi_line(cfg_multi_line), .in_push(in_push),
    .in_vld(in_vld), .in_fault(in_fault), .in_macro(in_macro), .in_ucnt(in_ucnt),
    .in_pc(in_pc), .in_ptaken(in_ptaken), .in_ptgt(in_ptgt), .in_op(in_op),
    .in_full(in_full), .ds_can_reserve(ds_can_reserve), .out_valid(out_valid),
    .out_slot_vld(out_slot_vld), .out_kind(out_kind), .out_pc(out_pc),
    .out_upc(out_upc), .out_ptaken(out_ptaken), .out_ptgt(out_ptgt),
    .out_op(out_op), .out_seq(out_seq));

  int n_chk = 0, n_fail = 0;
  string cur_tag = "R2";

  // reference model state
  mline_t mq[$];
  int m_ix = 0, m_up = 0, m_seq = 0;
  int exp_n;
  mout_t exp_o [OUT_W];
  int exp_s [OUT_W];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic int tval(input int k);
    return (k * 37 + 5) % (1 << OP_W);
  endfunction

  function automatic mslot_t mk(input bit v, input bit f, input bit m, input int n,
                                input int pc, input bit pt, input int pg, input int op);
    mslot_t s;
    s.v = v; s.f = f; s.m = m; s.n = UC_W'(n); s.pc = PC_W'(pc);
    s.pt = pt; s.pg = PC_W'(pg); s.op = OP_W'(op);
    return s;
  endfunction

  function automatic mline_t rnd_line();
    mline_t l;
    for (int k = 0; k < IN_W; k++) begin
      int r = int'($urandom % 10);
      l[k] = mk(r > 1, r == 2, (r == 3 || r == 4 || r == 2) && ($urandom % 2 == 0 || r != 2),
                int'($urandom % 8), int'($urandom), bit'($urandom % 2),
                int'($urandom), int'($urandom));
    end
    return l;
  endfunction

  task automatic m_emit(input int kind, input mslot_t s, input int up,
                        input bit pt, input int pg, input int op);
    exp_o[exp_n].k  = 2'(kind);
    exp_o[exp_n].pc = s.pc;
    exp_o[exp_n].up = UC_W'(up);
    exp_o[exp_n].pt = pt;
    exp_o[exp_n].pg = PC_W'(pg);
    exp_o[exp_n].op = OP_W'(op);
    exp_s[exp_n] = m_seq;
    m_seq = (m_seq + 1) % (1 << SEQ_W);
    exp_n++;
  endtask

  task automatic m_step(input bit cfg);
    int done = 0;
    while (exp_n < OUT_W && mq.size() > 0 && (done == 0 || (cfg && done == 1))) begin
      mslot_t s = mq[0][m_ix];
      bit used = 1'b0;
      if (!s.v) used = 1'b1;
      else if (s.f) begin
        m_emit(2, s, 0, s.pt, int'(s.pg), int'(s.op)); used = 1'b1;
      end else if (s.m) begin
        int total = (s.n == 0) ? 1 : int'(s.n);
        bit fin = (m_up + 1 == total);
        m_emit(1, s, m_up, fin ? s.pt : 1'b0, fin ? int'(s.pg) : 0,
               int'(s.op) ^ tval(m_up));
        if (fin) used = 1'b1; else m_up++;
      end else begin
        m_emit(0, s, 0, s.pt, int'(s.pg), int'(s.op)); used = 1'b1;
      end
      if (used) begin
        m_ix++; m_up = 0;
        if (m_ix == IN_W) begin
          void'(mq.pop_front()); m_ix = 0; done++;
        end
      end
    end
  endtask

  task automatic drive_line(input mline_t l);
    for (int k = 0; k < IN_W; k++) begin
      in_vld[k] = l[k].v; in_fault[k] = l[k].f; in_macro[k] = l[k].m;
      in_ptaken[k] = l[k].pt;
      in_ucnt[k*UC_W +: UC_W] = l[k].n;
      in_pc[k*PC_W +: PC_W] = l[k].pc;
      in_ptgt[k*PC_W +: PC_W] = l[k].pg;
      in_op[k*OP_W +: OP_W] = l[k].op;
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic cyc(input bit push, input mline_t l, input bit ds, input bit cfg);
    bit push_ok;
    in_push = push; drive_line(l); ds_can_reserve = ds; cfg_multi_line = cfg;
    push_ok = push && (mq.size() < DEPTH);
    exp_n = 0;
    if (ds) m_step(cfg);
    if (push_ok) mq.push_back(l);
    @(negedge clk);
    in_push = 1'b0;
    chk(out_valid == (exp_n > 0), ds ? cur_tag : "R10", "out_valid", out_valid, exp_n > 0);
    for (int k = 0; k < OUT_W; k++) begin
      chk(out_slot_vld[k] == (k < exp_n), ds ? cur_tag : "R10", "slot_vld",
          out_slot_vld[k], k < exp_n);
      if (k < exp_n && out_slot_vld[k]) begin
        mout_t a;
        string tg;
        a.k = out_kind[k*2 +: 2]; a.pc = out_pc[k*PC_W +: PC_W];
        a.up = out_upc[k*UC_W +: UC_W]; a.pt = out_ptaken[k];
        a.pg = out_ptgt[k*PC_W +: PC_W]; a.op = out_op[k*OP_W +: OP_W];
        tg = (exp_o[k].k == 2'd1) ? (exp_o[k].pt ? "R6" : "R5") :
             (exp_o[k].k == 2'd2) ? "R4" : "R2";
        chk(a == exp_o[k], tg, "slot fields", longint'(a), longint'(exp_o[k]));
        chk(out_seq[k*SEQ_W +: SEQ_W] == SEQ_W'(exp_s[k]), "R8", "seq",
            out_seq[k*SEQ_W +: SEQ_W], exp_s[k]);
      end
    end
    chk(in_full == (mq.size() == DEPTH), "R11", "in_full", in_full, mq.size() == DEPTH);
  endtask

  task automatic idle(input int n, input bit cfg);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b1, cfg);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    mline_t l;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    chk(out_slot_vld == '0, "R1", "slot_vld", out_slot_vld, 0);
    chk(in_full == 1'b0, "R1", "in_full", in_full, 0);

    // R1/R2: plain line, first sequence number is 0
    cur_tag = "R2";
    for (int k = 0; k < IN_W; k++) l[k] = mk(1, 0, 0, 0, 16'h100 + k, k == 3, 16'h200, 8'h10 + k);
    cyc(1'b1, l, 1'b1, 1'b0);
    idle(2, 1'b0);

    // R3: bubbles dropped, all-bubble line gives no output
    cur_tag = "R3";
    l[0] = mk(1, 0, 0, 0, 16'h300, 0, 0, 8'h31);
    l[1] = mk(0, 0, 0, 0, 16'h304, 1, 5, 8'h32);
    l[2] = mk(0, 1, 1, 3, 16'h308, 0, 0, 8'h33);
    l[3] = mk(1, 0, 0, 0, 16'h30c, 0, 0, 8'h34);
    cyc(1'b1, l, 1'b1, 1'b0);
    cyc(1'b1, '0, 1'b1, 1'b0);
    idle(2, 1'b0);

    // R4: faults forwarded unchanged, even when flagged macro
    cur_tag = "R4";
    l[0] = mk(1, 1, 1, 5, 16'h400, 1, 16'h4400, 8'h41);
    l[1] = mk(1, 1, 0, 0, 16'h404, 0, 16'h4404, 8'h42);
    l[2] = mk(1, 0, 0, 0, 16'h408, 0, 0, 8'h43);
    l[3] = mk(0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1'b1, l, 1'b1, 1'b0);
    idle(2, 1'b0);

    // R5/R6/R7: macro of six spans two cycles; count 0 gives one micro-op
    cur_tag = "R7";
    l[0] = mk(1, 0, 1, 6, 16'h500, 1, 16'h5555, 8'h50);
    l[1] = mk(1, 0, 0, 0, 16'h504, 0, 0, 8'h51);
    l[2] = mk(1, 0, 1, 0, 16'h508, 1, 16'h5a5a, 8'h52);
    l[3] = mk(1, 0, 1, 7, 16'h50c, 1, 16'h5f5f, 8'h53);
    cyc(1'b1, l, 1'b1, 1'b0);
    cur_tag = "R5";
    idle(4, 1'b0);

    // R10: stall with work pending, then release
    cur_tag = "R10";
    for (int k = 0; k < IN_W; k++) l[k] = mk(1, 0, k == 1, 3, 16'h600 + k, 1, 16'h66, 8'h60 + k);
    cyc(1'b1, l, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b0, 1'b0);
    idle(3, 1'b0);

    // R9: two half-bubble lines, separate then merged
    cur_tag = "R9";
    for (int k = 0; k < IN_W; k++) l[k] = mk(k < 2, 0, 0, 0, 16'h700 + k, 0, 0, 8'h70 + k);
    cyc(1'b1, l, 1'b0, 1'b0);
    cyc(1'b1, l, 1'b0, 1'b0);
    cyc(1'b0, '0, 1'b1, 1'b0);
    cyc(1'b0, '0, 1'b1, 1'b0);
    cyc(1'b1, l, 1'b0, 1'b1);
    cyc(1'b1, l, 1'b0, 1'b1);
    cyc(1'b0, '0, 1'b1, 1'b1);
    idle(2, 1'b1);

    // R11: fill the buffer while stalled, extra push is dropped
    cur_tag = "R11";
    for (int i = 0; i < DEPTH + 2; i++) begin
      for (int k = 0; k < IN_W; k++) l[k] = mk(1, 0, 0, 0, 16'h800 + 16*i + k, 0, 0, i);
      cyc(1'b1, l, 1'b0, 1'b0);
    end
    idle(DEPTH + 2, 1'b0);

    // random traffic, wraps the sequence counter (R8)
    cur_tag = "R8";
    for (int i = 0; i < 4000; i++) begin
      bit cfg = ((i / 250) % 2) == 1;
      cyc(($urandom % 2) == 1, rnd_line(), ($urandom % 5) != 0, cfg);
    end
    idle(20, 1'b1);

    summary();
    $finish;
  end
endmodule